// File: doc/BRIEF.md
# Double-Data-Rate Mode Register and Burst Column Sequencer

This block keeps the operating mode of a double-data-rate SDRAM controller and turns each burst request into the column addresses that the burst visits. A mode-set strobe, qualified by a bank-select value of zero, loads three settings from the address bus: burst length (2, 4 or 8), wrap order (sequential or interleaved) and CAS latency code (2 or 2.5 clocks). An illegal length or latency code is refused: the stored mode stays as it was and an error pulse is raised.

A burst-start strobe carries the first column. Data moves on both clock edges, so the sequencer presents two column addresses per clock, one for each beat of that clock. A burst of length BL therefore occupies BL/2 cycles. The column bits below the burst length wrap, either by adding the beat number or by XOR with it, and the bits above stay fixed. The programmed latency code is exported so that the read-data path can align its capture point. A new burst start abandons any burst in flight.

Top module: `ddr_burst_seq`

## Requirements
- R1: After reset no beat is valid, the last flag is low, the error flag is low and the mode is burst length 2, sequential order, latency code 3'b010, so a burst started before any mode set returns two columns in one cycle.
- R2: A mode-set strobe with bank value 2'b00 and legal codes (address bits 2:0 length: 001=2, 010=4, 011=8; bit 3 order: 0 sequential, 1 interleaved; bits 6:4 latency: 010=2, 110=2.5) updates the mode, and `cas_code` shows the new code in the cycle after the strobe.
- R3: A bank-zero mode-set strobe whose length code or latency code is not legal raises `mode_err` for exactly the cycle after the strobe and leaves length, order and latency unchanged.
- R4: A mode-set strobe with a nonzero bank value changes nothing and raises no error.
- R5: A burst start makes `beat_vld` high from the next cycle for exactly BL/2 consecutive cycles; it is low again after that.
- R6: In sequential order, beat b of a burst uses low column bits (start + b) modulo BL.
- R7: In interleaved order, beat b uses low column bits start XOR b.
- R8: The column bits at and above log2(BL) equal those of the starting column for every beat; a wrap never carries into them.
- R9: `beat_last` is high only in the final valid cycle of a burst.
- R10: A burst start during a burst drops the old sequence and the next cycle shows beats 0 and 1 of the new column.
- R11: Length and order are captured when a burst starts; a mode set during the burst affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mrs_stb | input | 1 | Mode-set command strobe |
| mrs_bank | input | 2 | Bank-select value sampled with the mode-set strobe |
| mrs_addr | input | 13 | Address bus carrying the mode fields |
| bst_stb | input | 1 | Burst start strobe |
| bst_col | input | 10 | Starting column of the burst |
| col_beat0 | output | 10 | Column of the first beat in this cycle |
| col_beat1 | output | 10 | Column of the second beat in this cycle |
| beat_vld | output | 1 | Both beat columns are valid this cycle |
| beat_last | output | 1 | This cycle carries the final two beats |
| cas_code | output | 3 | Programmed CAS latency code, bit 2 marks the half cycle |
| mode_err | output | 1 | One-cycle pulse after a refused mode set |

## Verification
The bench aims at starting columns whose low bits sit at the top of the wrap window, such as 0x3FF at length 8, where a design that let the increment carry upward would change the row of columns it visits. It loads illegal length and latency codes and mode sets to other banks, where a design that stored fields piecemeal would leave a mixed mode visible in `cas_code` or the next burst's length. It restarts a burst midway, which catches a counter that is not cleared, and rewrites the mode mid-burst, which catches a sequencer that reads the live mode instead of the captured one.

// File: rtl/ddr_burst_pkg.sv
// Package: shared mode types, field positions and decode helpers for the
// burst column sequencer. Assumes burst length never exceeds 8.
package ddr_burst_pkg;

    // Field positions inside the mode-set address word; the decode depends on them.
    localparam int BL_LSB = 0;
    localparam int BT_BIT = 3;
    localparam int CL_LSB = 4;
    localparam int CODE_W = 3;

    // Beat numbering: up to 8 beats, two per clock.
    localparam int BEAT_W     = 3;
    localparam int PAIR_IDX_W = BEAT_W - 1;

    localparam logic [CODE_W-1:0] CAS_CODE_2  = 3'b010;
    localparam logic [CODE_W-1:0] CAS_CODE_25 = 3'b110;

    typedef enum logic [1:0] {
        BLEN_2 = 2'd0,
        BLEN_4 = 2'd1,
        BLEN_8 = 2'd2
    } blen_e;

    typedef struct packed {
        blen_e             blen;
        logic              ilv;
        logic [CODE_W-1:0] cas;
    } mode_t;

    localparam mode_t MODE_RESET = '{blen: BLEN_2, ilv: 1'b0, cas: CAS_CODE_2};

    // True when the length code names a supported burst length.
    function automatic logic bl_code_ok(input logic [CODE_W-1:0] code);
        return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
    endfunction

    // True when the latency code names a supported latency.
    function automatic logic cas_code_ok(input logic [CODE_W-1:0] code);
        return (code == CAS_CODE_2) || (code == CAS_CODE_25);
    endfunction

    // Map a legal length code onto the internal enum.
    function automatic blen_e bl_decode(input logic [CODE_W-1:0] code);
        case (code)
            3'b010:  return BLEN_4;
            3'b011:  return BLEN_8;
            default: return BLEN_2;
        endcase
    endfunction

    // Mask of the column bits that wrap inside a burst.
    function automatic logic [BEAT_W-1:0] wrap_mask(input blen_e b);
        case (b)
            BLEN_4:  return 3'b011;
            BLEN_8:  return 3'b111;
            default: return 3'b001;
        endcase
    endfunction

    // Index of the final beat pair of a burst.
    function automatic logic [PAIR_IDX_W-1:0] last_pair(input blen_e b);
        case (b)
            BLEN_4:  return 2'd1;
            BLEN_8:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ddr_mode_reg.sv
// Module: mode register. Decodes a bank-zero mode-set command, stores length,
// order and latency when every code is legal, and pulses an error otherwise.
// Assumes the mode-set strobe is a single-cycle command.
module ddr_mode_reg
    import ddr_burst_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_stb,
    input  logic [BA_W-1:0]   mrs_bank,
    input  logic [ADDR_W-1:0] mrs_addr,
    output mode_t             mode_q,
    output logic              mode_err
);

    logic              hit;
    logic [CODE_W-1:0] bl_code;
    logic [CODE_W-1:0] cl_code;
    logic              legal;
    mode_t             mode_new;

    // Field extraction and legality of the incoming command.
    always_comb begin
        hit           = mrs_stb && (mrs_bank == '0);
        bl_code       = mrs_addr[BL_LSB +: CODE_W];
        cl_code       = mrs_addr[CL_LSB +: CODE_W];
        legal         = bl_code_ok(bl_code) && cas_code_ok(cl_code);
        mode_new.blen = bl_decode(bl_code);
        mode_new.ilv  = mrs_addr[BT_BIT];
        mode_new.cas  = cl_code;
    end

    // Store a legal mode as a whole; flag a refused one for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_RESET;
            mode_err <= 1'b0;
        end else begin
            mode_err <= hit && !legal;
            if (hit && legal) begin
                mode_q <= mode_new;
            end
        end
    end

endmodule

// File: rtl/ddr_burst_ctrl.sv
// Module: burst control. Captures the start column, length and order on a
// burst start and walks the beat-pair index until the final pair.
// Assumes a start strobe always wins over a running burst.
module ddr_burst_ctrl
    import ddr_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bst_stb,
    input  logic [COL_W-1:0]      bst_col,
    input  mode_t                 mode_q,
    output logic                  active,
    output logic [PAIR_IDX_W-1:0] pair_idx,
    output logic [COL_W-1:0]      base_col,
    output blen_e                 run_blen,
    output logic                  run_ilv,
    output logic                  at_last
);

    // Final pair of the burst in flight.
    always_comb begin
        at_last = active && (pair_idx == last_pair(run_blen));
    end

    // Burst state: restart on a strobe, step or finish otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            pair_idx <= '0;
            base_col <= '0;
            run_blen <= BLEN_2;
            run_ilv  <= 1'b0;
        end else if (bst_stb) begin
            active   <= 1'b1;
            pair_idx <= '0;
            base_col <= bst_col;
            run_blen <= mode_q.blen;
            run_ilv  <= mode_q.ilv;
        end else if (active) begin
            if (at_last) begin
                active   <= 1'b0;
                pair_idx <= '0;
            end else begin
                pair_idx <= pair_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ddr_col_calc.sv
// Module: column calculator for one beat. Wraps the low column bits by adding
// or XOR-ing the beat number and keeps the bits above the burst window.
// Assumes COL_W is wider than the largest wrap window.
module ddr_col_calc
    import ddr_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]  base_col,
    input  logic [BEAT_W-1:0] beat,
    input  blen_e             blen,
    input  logic              ilv,
    output logic [COL_W-1:0]  col
);

    localparam int HI_W = COL_W - BEAT_W;

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] beat_ext;
    logic [COL_W-1:0] wrapped;

    // Select the wrap rule and merge the fixed upper bits back in.
    always_comb begin
        mask     = {{HI_W{1'b0}}, wrap_mask(blen)};
        beat_ext = {{HI_W{1'b0}}, beat};
        wrapped  = ilv ? (base_col ^ beat_ext) : (base_col + beat_ext);
        col      = (base_col & ~mask) | (wrapped & mask);
    end

endmodule

// File: rtl/ddr_burst_seq.sv
// Module: top of the mode register and burst column sequencer. Presents two
// beat columns per clock for a double-data-rate burst and exports the stored
// latency code. Assumes commands arrive already decoded into strobes.
module ddr_burst_seq
    import ddr_burst_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_stb,
    input  logic [BA_W-1:0]   mrs_bank,
    input  logic [ADDR_W-1:0] mrs_addr,
    input  logic              bst_stb,
    input  logic [COL_W-1:0]  bst_col,
    output logic [COL_W-1:0]  col_beat0,
    output logic [COL_W-1:0]  col_beat1,
    output logic              beat_vld,
    output logic              beat_last,
    output logic [2:0]        cas_code,
    output logic              mode_err
);

    localparam int BEATS_PER_CLK = 2;

    mode_t                 mode_q;
    logic                  active;
    logic [PAIR_IDX_W-1:0] pair_idx;
    logic [COL_W-1:0]      base_col;
    blen_e                 run_blen;
    logic                  run_ilv;
    logic                  at_last;
    logic [COL_W-1:0]      beat_col [BEATS_PER_CLK];

    ddr_mode_reg #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mrs_stb  (mrs_stb),
        .mrs_bank (mrs_bank),
        .mrs_addr (mrs_addr),
        .mode_q   (mode_q),
        .mode_err (mode_err)
    );

    ddr_burst_ctrl #(
        .COL_W (COL_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bst_stb  (bst_stb),
        .bst_col  (bst_col),
        .mode_q   (mode_q),
        .active   (active),
        .pair_idx (pair_idx),
        .base_col (base_col),
        .run_blen (run_blen),
        .run_ilv  (run_ilv),
        .at_last  (at_last)
    );

    // One calculator per beat carried in a clock cycle.
    for (genvar g = 0; g < BEATS_PER_CLK; g++) begin : g_beat
        logic [BEAT_W-1:0] beat_no;
        assign beat_no = {pair_idx, 1'(g)};
        ddr_col_calc #(
            .COL_W (COL_W)
        ) u_calc (
            .base_col (base_col),
            .beat     (beat_no),
            .blen     (run_blen),
            .ilv      (run_ilv),
            .col      (beat_col[g])
        );
    end

    // Drive the outputs, holding columns at zero between bursts.
    always_comb begin
        beat_vld  = active;
        beat_last = at_last;
        col_beat0 = active ? beat_col[0] : '0;
        col_beat1 = active ? beat_col[1] : '0;
        cas_code  = mode_q.cas;
    end

endmodule

// File: rtl/ddr_burst_seq_chk.sv
// Module: property checker for the burst column sequencer, bound to the top.
// Assumes only port-level visibility of the sequencer.
module ddr_burst_seq_chk #(
    parameter int COL_W = 10,
    parameter int BA_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mrs_stb,
    input logic [BA_W-1:0]  mrs_bank,
    input logic             bst_stb,
    input logic [COL_W-1:0] bst_col,
    input logic [COL_W-1:0] col_beat0,
    input logic [COL_W-1:0] col_beat1,
    input logic             beat_vld,
    input logic             beat_last,
    input logic [2:0]       cas_code,
    input logic             mode_err
);

    // R9
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_vld);

    // R5
    start_gives_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bst_stb |=> beat_vld);

    // R9
    burst_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !bst_stb) |=> !beat_vld);

    // R10
    restart_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bst_stb |=> (col_beat0 == $past(bst_col)));

    // R4
    other_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_stb && (mrs_bank != '0)) |=> (!mode_err && $stable(cas_code)));

    // R3
    refused_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> $stable(cas_code));

    // R8
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld |-> (col_beat0[COL_W-1:3] == col_beat1[COL_W-1:3]));

endmodule

bind ddr_burst_seq ddr_burst_seq_chk #(
    .COL_W (COL_W),
    .BA_W  (BA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrs_stb   (mrs_stb),
    .mrs_bank  (mrs_bank),
    .bst_stb   (bst_stb),
    .bst_col   (bst_col),
    .col_beat0 (col_beat0),
    .col_beat1 (col_beat1),
    .beat_vld  (beat_vld),
    .beat_last (beat_last),
    .cas_code  (cas_code),
    .mode_err  (mode_err)
);

// File: tb/ddr_burst_seq_bench.sv
module ddr_burst_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mrs_stb = 1'b0;
    logic [1:0]  mrs_bank = '0;
    logic [12:0] mrs_addr = '0;
    logic        bst_stb = 1'b0;
    logic [9:0]  bst_col = '0;
    logic [9:0]  col_beat0;
    logic [9:0]  col_beat1;
    logic        beat_vld;
    logic        beat_last;
    logic [2:0]  cas_code;
    logic        mode_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ddr_burst_seq u_ddr_burst_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mrs_stb   (mrs_stb),
        .mrs_bank  (mrs_bank),
        .mrs_addr  (mrs_addr),
        .bst_stb   (bst_stb),
        .bst_col   (bst_col),
        .col_beat0 (col_beat0),
        .col_beat1 (col_beat1),
        .beat_vld  (beat_vld),
        .beat_last (beat_last),
        .cas_code  (cas_code),
        .mode_err  (mode_err)
    );

    typedef struct packed {
        logic [2:0]  bl;
        logic        ilv;
        logic [9:0]  start;
        logic [79:0] exp;
    } vec_t;

    // Expected beat columns, beat 0 in the top ten bits.
    localparam vec_t VECS [8] = '{
        '{3'b011, 1'b0, 10'h005, {10'h005,10'h006,10'h007,10'h000,10'h001,10'h002,10'h003,10'h004}},
        '{3'b011, 1'b1, 10'h005, {10'h005,10'h004,10'h007,10'h006,10'h001,10'h000,10'h003,10'h002}},
        '{3'b010, 1'b0, 10'h3F6, {10'h3F6,10'h3F7,10'h3F4,10'h3F5,40'h0}},
        '{3'b010, 1'b1, 10'h3F7, {10'h3F7,10'h3F6,10'h3F5,10'h3F4,40'h0}},
        '{3'b001, 1'b0, 10'h201, {10'h201,10'h200,60'h0}},
        '{3'b001, 1'b1, 10'h12A, {10'h12A,10'h12B,60'h0}},
        // R8: no carry out of the wrap window
        '{3'b011, 1'b0, 10'h3FF, {10'h3FF,10'h3F8,10'h3F9,10'h3FA,10'h3FB,10'h3FC,10'h3FD,10'h3FE}},
        '{3'b011, 1'b1, 10'h0AA, {10'h0AA,10'h0AB,10'h0A8,10'h0A9,10'h0AE,10'h0AF,10'h0AC,10'h0AD}}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] mw(input logic [2:0] bl, input logic ilv, input logic [2:0] cl);
        return {6'b0, cl, ilv, bl};
    endfunction

    // Mode-set command; returns with the cycle after the strobe visible.
    task automatic mrs(input logic [1:0] ba, input logic [12:0] a);
        @(negedge clk);
        mrs_stb = 1'b1; mrs_bank = ba; mrs_addr = a;
        @(negedge clk);
        mrs_stb = 1'b0;
    endtask

    // Burst start; returns with the first beat pair visible.
    task automatic start(input logic [9:0] c);
        @(negedge clk);
        bst_stb = 1'b1; bst_col = c;
        @(negedge clk);
        bst_stb = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 vld", beat_vld, 0);
        chk("R1 last", beat_last, 0);
        chk("R1 cas", cas_code, 3'b010);
        chk("R1 err", mode_err, 0);
        start(10'h00B);
        chk("R1 col0", col_beat0, 10'h00B);
        chk("R1 col1", col_beat1, 10'h00A);
        chk("R1 last", beat_last, 1);
        @(negedge clk);
        chk("R1 end", beat_vld, 0);

        // Table walk over lengths, orders and start columns.
        for (int v = 0; v < 8; v++) begin
            int np;
            np = 1 << (VECS[v].bl - 1);
            mrs(2'b00, mw(VECS[v].bl, VECS[v].ilv, 3'b010));
            chk("R2 err", mode_err, 0);
            start(VECS[v].start);
            for (int p = 0; p < np; p++) begin
                chk("R5 vld", beat_vld, 1);
                chk(VECS[v].ilv ? "R7 col0" : "R6 col0", col_beat0, VECS[v].exp[79-20*p -: 10]);
                chk(VECS[v].ilv ? "R7 col1" : "R6 col1", col_beat1, VECS[v].exp[69-20*p -: 10]);
                chk("R9 last", beat_last, (p == np-1) ? 1 : 0);
                @(negedge clk);
            end
            chk("R5 end", beat_vld, 0);
        end

        // R2: half-cycle latency with length 8 sequential.
        mrs(2'b00, mw(3'b011, 1'b0, 3'b110));
        chk("R2 err", mode_err, 0);
        chk("R2 cas", cas_code, 3'b110);

        // R3: illegal length code.
        mrs(2'b00, mw(3'b000, 1'b1, 3'b010));
        chk("R3 err", mode_err, 1);
        chk("R3 cas", cas_code, 3'b110);
        @(negedge clk);
        chk("R3 pulse", mode_err, 0);
        start(10'h010);
        chk("R3 col1", col_beat1, 10'h011);
        chk("R3 len", beat_last, 0);
        repeat (3) @(negedge clk);
        chk("R3 last", beat_last, 1);
        chk("R3 col0", col_beat0, 10'h016);
        @(negedge clk);

        // R3: illegal latency code.
        mrs(2'b00, mw(3'b010, 1'b1, 3'b011));
        chk("R3 err", mode_err, 1);
        chk("R3 cas", cas_code, 3'b110);
        start(10'h005);
        chk("R3 order", col_beat1, 10'h006);
        chk("R3 len", beat_last, 0);
        repeat (4) @(negedge clk);

        // R4: other banks ignored, legal or not.
        mrs(2'b01, mw(3'b001, 1'b1, 3'b010));
        chk("R4 err", mode_err, 0);
        chk("R4 cas", cas_code, 3'b110);
        mrs(2'b10, 13'h0);
        chk("R4 err", mode_err, 0);
        start(10'h020);
        chk("R4 order", col_beat1, 10'h021);
        chk("R4 len", beat_last, 0);
        repeat (4) @(negedge clk);

        // R10: restart in the middle of a burst.
        start(10'h000);
        chk("R10 first", col_beat0, 10'h000);
        @(negedge clk);
        bst_stb = 1'b1; bst_col = 10'h013;
        @(negedge clk);
        bst_stb = 1'b0;
        chk("R10 col0", col_beat0, 10'h013);
        chk("R10 col1", col_beat1, 10'h014);
        chk("R10 last", beat_last, 0);
        repeat (3) @(negedge clk);
        chk("R10 tail", col_beat0, 10'h011);
        chk("R10 end", beat_last, 1);
        @(negedge clk);

        // R11: mode set during a burst does not disturb it.
        start(10'h000);
        mrs_stb = 1'b1; mrs_bank = 2'b00; mrs_addr = mw(3'b001, 1'b1, 3'b010);
        @(negedge clk);
        mrs_stb = 1'b0;
        chk("R11 col0", col_beat0, 10'h002);
        chk("R11 col1", col_beat1, 10'h003);
        chk("R11 last", beat_last, 0);
        chk("R2 cas", cas_code, 3'b010);
        repeat (2) @(negedge clk);
        chk("R11 tail", col_beat0, 10'h006);
        chk("R11 end", beat_last, 1);
        @(negedge clk);
        chk("R11 idle", beat_vld, 0);
        start(10'h005);
        chk("R11 new col0", col_beat0, 10'h005);
        chk("R11 new col1", col_beat1, 10'h004);
        chk("R11 new last", beat_last, 1);
        @(negedge clk);

        // R8: top of a length-4 window keeps its upper bits.
        mrs(2'b00, mw(3'b010, 1'b0, 3'b010));
        start(10'h3FE);
        chk("R8 col1", col_beat1, 10'h3FF);
        @(negedge clk);
        chk("R8 upper", col_beat0[9:2], 8'hFF);
        chk("R8 col0", col_beat0, 10'h3FC);
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule